// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a first-in first-out buffer for 9-bit words. Its writer and its reader each run on their own clock. The two clocks may come from one source or may be unrelated. Each side accepts a transfer only when both of its enables are active. One enable is active low and the other is active high. The block drives four status flags. Two are exact: empty and full. Two are programmable: almost-empty and almost-full. Each programmable flag compares the occupancy, or the free space, with a 9-bit offset register.

Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy crosses into the other clock domain through a two-flop synchronizer. The write side computes full and almost-full. The read side computes empty and almost-empty. All four flags are registered. Read data leaves through an output register. An output-enable input decides whether that register's value is presented on the data pins. The same input also drives a drive-valid pin in place of a three-state pad.

The offset registers are loaded through the write port. A reset taken while the high-active write enable is held low puts the block into load mode. That mode then lasts until the next reset.

Top module: `dc_flag_fifo`

## Requirements
- R1: During and after reset, empty and almost_empty are 1, full and almost_full are 0, rd_data is 0, and both offsets are 7.
- R2: A word is written on each wr_clk rising edge where wr_ena_n is 0, wr_enb_ld is 1 and full is 0. A burst of back-to-back writes stores one word per cycle.
- R3: A write attempted while full is 1 stores nothing and does not move the write pointer. Later reads return only the words accepted before full.
- R4: A word is read on each rd_clk rising edge where rd_ena_n is 0, rd_enb is 1 and empty is 0. The oldest word appears in the output register right after that edge, and words leave in write order.
- R5: A read attempted while empty is 1 leaves the output register unchanged.
- R6: With the clocks tied, empty falls on the third edge after the write edge that ended it, and full falls on the third edge after the read edge that ended it. This latency is one register per synchronizer stage plus the flag register.
- R7: almost_empty is 1 when the occupancy the reader sees is at or below the almost-empty offset. almost_full is 1 when the free space the writer sees is at or below the almost-full offset. Both offsets default to 7.
- R8: If wr_enb_ld is 0 during reset, load mode is entered. In load mode, each wr_clk edge with wr_ena_n = 0 and wr_enb_ld = 0 loads wr_data into an offset register. The loads rotate almost-empty, almost-full, almost-empty, and so on. In load mode, wr_enb_ld = 1 with wr_ena_n = 0 is still an ordinary write.
- R9: When rd_oe is 1, rd_drive is 1 and rd_data shows the output register. When rd_oe is 0, rd_drive is 0 and rd_data is 0.
- R10: A read and a write in the same cycle are both accepted when their flags allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| wr_ena_n | input | 1 | Write enable, active low |
| wr_enb_ld | input | 1 | Write enable, active high; its level during reset selects load mode |
| wr_data | input | 9 | Write data, or offset value while loading |
| rd_ena_n | input | 1 | Read enable, active low |
| rd_enb | input | 1 | Read enable, active high |
| rd_oe | input | 1 | Output enable |
| rd_data | output | 9 | Read data, zero when rd_oe is 0 |
| rd_drive | output | 1 | Drive-valid, follows rd_oe |
| empty | output | 1 | No word visible to the reader |
| almost_empty | output | 1 | Occupancy at or below the almost-empty offset |
| full | output | 1 | No free space visible to the writer |
| almost_full | output | 1 | Free space at or below the almost-full offset |

## Verification
The bench builds the block with ADDR_W = 4, which gives a 16-word buffer. At that depth a full condition is reached in sixteen writes, so writes attempted while full, the fall of full after a drain, and a stream that keeps the buffer half full can all be exercised within a few hundred cycles. Both clocks come from one source, which makes the three-edge flag latency deterministic and lets the model predict every flag on every edge. Offsets of 3 and 2 are loaded so that each almost flag is seen crossing its threshold in both directions.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
  localparam int DATA_W = 9;
  localparam int OFS_W  = 9;
  localparam logic [OFS_W-1:0] OFS_DEFAULT = 9'd7;

  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/fifo_ptr_sync.sv
// Two-flop synchronizer for a Gray pointer, followed by Gray-to-binary decode.
module fifo_ptr_sync #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_decode
    assign bin_out[i] = ^stage2[PW-1:i];
  end
endmodule

// File: rtl/fifo_dpram.sv
// Simple dual-port storage: one write port, one registered read port.
module fifo_dpram #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [0:WORDS-1];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/fifo_wr_side.sv
// Write pointer, full / almost-full flags and the offset registers.
module fifo_wr_side
  import fifo_flag_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ena_n,
  input  logic             enb_ld,
  input  logic [OFS_W-1:0] wdata_ofs,
  input  logic [AW:0]      rbin_sync,
  output logic             wr_do,
  output logic [AW-1:0]    waddr,
  output logic [AW:0]      wgray,
  output logic             full,
  output logic             almost_full,
  output logic [OFS_W-1:0] ae_ofs
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = (AW + 1 > OFS_W) ? AW + 1 : OFS_W;
  localparam logic [AW:0] DEPTH_V = (AW + 1)'(DEPTH);

  logic [AW:0]      wbin, wbin_nx, occ_nx, free_nx, occ_now;
  logic [OFS_W-1:0] af_ofs;
  logic             load_mode, wr_req, ld_req;
  ofs_sel_e         sel;

  assign wr_req  = !ena_n && enb_ld;
  assign ld_req  = load_mode && !ena_n && !enb_ld;
  assign wr_do   = wr_req && !full && !rst;
  assign wbin_nx = wbin + {{AW{1'b0}}, wr_do};
  assign occ_nx  = wbin_nx - rbin_sync;
  assign free_nx = DEPTH_V - occ_nx;
  assign occ_now = wbin - rbin_sync;
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      wbin        <= wbin_nx;
      wgray       <= wbin_nx ^ (wbin_nx >> 1);
      full        <= (occ_nx == DEPTH_V);
      almost_full <= (CW'(free_nx) <= CW'(af_ofs));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_mode <= !enb_ld;
      sel       <= SEL_AE;
      ae_ofs    <= OFS_DEFAULT;
      af_ofs    <= OFS_DEFAULT;
    end else if (ld_req) begin
      if (sel == SEL_AE) ae_ofs <= wdata_ofs;
      else               af_ofs <= wdata_ofs;
      sel <= (sel == SEL_AE) ? SEL_AF : SEL_AE;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    occ_now <= DEPTH_V);
  assert_full_has_afull_R7: assert property (@(posedge clk) disable iff (rst)
    full |-> almost_full);
  assert_wgray_step_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
  assert_ofs_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load_mode |=> ($stable(af_ofs) && $stable(ae_ofs)));
endmodule

// File: rtl/fifo_rd_side.sv
// Read pointer, empty / almost-empty flags, local copy of the almost-empty offset.
module fifo_rd_side
  import fifo_flag_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ena_n,
  input  logic             enb,
  input  logic [AW:0]      wbin_sync,
  input  logic [OFS_W-1:0] ae_ofs_in,
  output logic             rd_do,
  output logic [AW-1:0]    raddr,
  output logic [AW:0]      rgray,
  output logic             empty,
  output logic             almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = (AW + 1 > OFS_W) ? AW + 1 : OFS_W;
  localparam logic [AW:0] DEPTH_V = (AW + 1)'(DEPTH);

  logic [AW:0]      rbin, rbin_nx, occ_nx, occ_now;
  logic [OFS_W-1:0] ae_s1, ae_s2;
  logic             rd_req;

  assign rd_req  = !ena_n && enb;
  assign rd_do   = rd_req && !empty && !rst;
  assign rbin_nx = rbin + {{AW{1'b0}}, rd_do};
  assign occ_nx  = wbin_sync - rbin_nx;
  assign occ_now = wbin_sync - rbin;
  assign raddr   = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin         <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
      ae_s1        <= OFS_DEFAULT;
      ae_s2        <= OFS_DEFAULT;
    end else begin
      rbin         <= rbin_nx;
      rgray        <= rbin_nx ^ (rbin_nx >> 1);
      empty        <= (occ_nx == '0);
      almost_empty <= (CW'(occ_nx) <= CW'(ae_s2));
      ae_s1        <= ae_ofs_in;
      ae_s2        <= ae_s1;
    end
  end

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    occ_now <= DEPTH_V);
  assert_empty_has_aempty_R7: assert property (@(posedge clk) disable iff (rst)
    empty |-> almost_empty);
  assert_rgray_step_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dc_flag_fifo.sv
module dc_flag_fifo
  import fifo_flag_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              wr_ena_n,
  input  logic              wr_enb_ld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ena_n,
  input  logic              rd_enb,
  input  logic              rd_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              empty,
  output logic              almost_empty,
  output logic              full,
  output logic              almost_full
);
  logic [ADDR_W:0]   wgray, rgray, wbin_sync, rbin_sync;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [OFS_W-1:0]  ae_ofs;
  logic [DATA_W-1:0] rd_q;
  logic              wr_do, rd_do;

  fifo_wr_side #(.AW(ADDR_W)) u_wr (
    .clk(wr_clk), .rst(rst), .ena_n(wr_ena_n), .enb_ld(wr_enb_ld),
    .wdata_ofs(wr_data), .rbin_sync(rbin_sync), .wr_do(wr_do), .waddr(waddr),
    .wgray(wgray), .full(full), .almost_full(almost_full), .ae_ofs(ae_ofs)
  );

  fifo_rd_side #(.AW(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rst), .ena_n(rd_ena_n), .enb(rd_enb),
    .wbin_sync(wbin_sync), .ae_ofs_in(ae_ofs), .rd_do(rd_do), .raddr(raddr),
    .rgray(rgray), .empty(empty), .almost_empty(almost_empty)
  );

  fifo_ptr_sync #(.PW(ADDR_W + 1)) u_w2r (
    .clk(rd_clk), .rst(rst), .gray_in(wgray), .bin_out(wbin_sync)
  );

  fifo_ptr_sync #(.PW(ADDR_W + 1)) u_r2w (
    .clk(wr_clk), .rst(rst), .gray_in(rgray), .bin_out(rbin_sync)
  );

  fifo_dpram #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .wr_clk(wr_clk), .wr_en(wr_do), .wr_addr(waddr), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst(rst), .rd_en(rd_do), .rd_addr(raddr), .rd_q(rd_q)
  );

  assign rd_data  = rd_oe ? rd_q : '0;
  assign rd_drive = rd_oe;

  assert_hold_on_empty_R5: assert property (@(posedge rd_clk) disable iff (rst)
    (!rd_ena_n && rd_enb && empty) |=> $stable(rd_q));
endmodule

// File: tb/tb_dc_flag_fifo.sv
module tb_dc_flag_fifo;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1, wa_n = 1'b1, wb = 1'b1, ra_n = 1'b1, rb = 1'b0, oe = 1'b0;
  logic [8:0] wd = '0;
  logic [8:0] rd_data;
  logic       rd_drive, empty, almost_empty, full, almost_full;

  dc_flag_fifo #(.ADDR_W(AW)) dut (
    .wr_clk(clk), .rd_clk(clk), .rst(rst), .wr_ena_n(wa_n), .wr_enb_ld(wb),
    .wr_data(wd), .rd_ena_n(ra_n), .rd_enb(rb), .rd_oe(oe), .rd_data(rd_data),
    .rd_drive(rd_drive), .empty(empty), .almost_empty(almost_empty),
    .full(full), .almost_full(almost_full)
  );

  int    checks = 0, errors = 0;
  string phase  = "R1";

  // behavioural reference model
  int         whist[3], rhist[3], aeh[3];
  int         ae_m, af_m;
  bit         lm, sel;
  bit         m_full, m_afull, m_empty, m_aempty;
  int         m_q;
  int         dq[$];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void model_edge();
    bit aw, ar, ld;
    int wn, rn;
    if (rst) begin
      lm = !wb; sel = 0; ae_m = 7; af_m = 7;
      for (int k = 0; k < 3; k++) begin whist[k] = 0; rhist[k] = 0; aeh[k] = 7; end
      m_full = 0; m_afull = 0; m_empty = 1; m_aempty = 1; m_q = 0;
      dq.delete();
    end else begin
      aw = !wa_n && wb && !m_full;
      ar = !ra_n && rb && !m_empty;
      ld = lm && !wa_n && !wb;
      if (aw) dq.push_back(int'(wd));
      if (ar) m_q = dq.pop_front();
      wn = whist[0] + int'(aw);
      rn = rhist[0] + int'(ar);
      m_full   = (wn - rhist[2]) == D;
      m_afull  = (D - (wn - rhist[2])) <= af_m;
      m_empty  = (whist[2] == rn);
      m_aempty = (whist[2] - rn) <= aeh[2];
      if (ld) begin
        if (!sel) ae_m = int'(wd); else af_m = int'(wd);
        sel = !sel;
      end
      for (int k = 2; k > 0; k--) begin
        whist[k] = whist[k-1]; rhist[k] = rhist[k-1]; aeh[k] = aeh[k-1];
      end
      whist[0] = wn; rhist[0] = rn; aeh[0] = ae_m;
    end
  endfunction

  task automatic compare();
    chk(phase, "empty",        empty,        m_empty);
    chk(phase, "almost_empty", almost_empty, m_aempty);
    chk(phase, "full",         full,         m_full);
    chk(phase, "almost_full",  almost_full,  m_afull);
    chk(phase, "rd_data",      rd_data,      oe ? m_q : 0);
    chk(phase, "rd_drive",     rd_drive,     oe);
  endtask

  task automatic step(bit i_rst, bit i_wa_n, bit i_wb, int i_wd,
                      bit i_ra_n, bit i_rb, bit i_oe);
    rst = i_rst; wa_n = i_wa_n; wb = i_wb; wd = 9'(i_wd);
    ra_n = i_ra_n; rb = i_rb; oe = i_oe;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 1, 1, 0, 1, 0, 1);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    phase = "R1";
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 1, 0, 1);
    chk("R1", "empty",        empty,        1);
    chk("R1", "almost_empty", almost_empty, 1);
    chk("R1", "full",         full,         0);
    chk("R1", "almost_full",  almost_full,  0);
    chk("R1", "rd_data",      rd_data,      0);
    idle(2);

    phase = "R5";
    for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 0, 1, 1);

    phase = "R2";
    for (int i = 0; i < 5; i++) step(0, 0, 1, 10 + i, 1, 0, 1);
    phase = "R6";
    idle(3);

    phase = "R4";
    for (int i = 0; i < 6; i++) step(0, 1, 1, 0, 0, 1, 1);
    idle(3);

    phase = "R3";
    for (int i = 0; i < D + 4; i++) step(0, 0, 1, 100 + i, 1, 0, 1);
    idle(3);
    chk("R3", "full after overfill", full, 1);

    phase = "R6";
    step(0, 1, 1, 0, 0, 1, 1);
    idle(4);

    phase = "R9";
    for (int i = 0; i < 8; i++) step(0, 1, 1, 0, 0, 1, i % 2);
    idle(2);

    phase = "R10";
    for (int i = 0; i < 30; i++) step(0, 0, 1, 200 + i, 0, 1, 1);

    phase = "R4";
    for (int i = 0; i < D + 4; i++) step(0, 1, 1, 0, 0, 1, 1);
    idle(3);

    phase = "R8";
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 1, 0, 1);
    step(0, 0, 0, 5, 1, 0, 1);
    step(0, 0, 0, 2, 1, 0, 1);
    step(0, 0, 0, 3, 1, 0, 1);
    idle(4);

    phase = "R7";
    for (int i = 0; i < D; i++) begin
      step(0, 0, 1, 300 + i, 1, 0, 1);
      idle(1);
    end
    idle(3);
    chk("R7", "almost_full at full", almost_full, 1);
    for (int i = 0; i < D + 2; i++) begin
      step(0, 1, 1, 0, 0, 1, 1);
      idle(1);
    end
    idle(3);
    chk("R7", "almost_empty when drained", almost_empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule